// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Data Buffer Control

This block sits between a processor with a time-shared address/data bus and the memory and I/O devices behind it. Early in each bus cycle the processor puts a 20-bit address on its pins and raises an address strobe. The block passes that address through while the strobe is high and keeps it once the strobe falls. The memory side therefore sees a steady address for the whole cycle, even though the processor then reuses its low pins for data and its top four pins for status.

The block also steers the 8-bit data path. A direction pin selects processor-to-memory or memory-to-processor. An active-low enable pin decides whether either side is driven at all. The buffer's two sides come out as separate value and drive-enable pairs, so the surrounding logic resolves the shared wires. The read, write and memory/I-O select strobes go straight through to the memory side.

Top module: `adl_demux`

## Requirements
- R1: While `ale` is 1, `addr_out` equals the processor address pins in the same cycle, with no clock delay.
- R2: While `ale` is 0, `addr_out` holds the address that was on the pins at the last rising clock edge at which `ale` was 1. Changes on the address pins have no effect on it.
- R3: Status values placed on `a_top_in` after `ale` falls never appear on `addr_out[19:16]`.
- R4: Synchronous reset (`rst` = 1 at a rising edge) clears the held address to zero. With `ale` at 0 after reset, `addr_out` reads 0.
- R5: With `den_n` = 0 and `dt_r` = 1, `mem_drive_en` is 1, `mem_wdata` equals `ad_in` and `cpu_drive_en` is 0.
- R6: With `den_n` = 0 and `dt_r` = 0, `cpu_drive_en` is 1, `cpu_rdata` equals `mem_rdata` and `mem_drive_en` is 0.
- R7: With `den_n` = 1, whatever `dt_r` is, both drive enables are 0 and both `mem_wdata` and `cpu_rdata` read 0. The two enables are never 1 together.
- R8: `mem_rd_n`, `mem_wr_n` and `mem_io_m` follow `rd_n`, `wr_n` and `io_m` combinationally.
- R9: Bit placement on the address bus: `addr_out[7:0]` comes from `ad_in`, `addr_out[15:8]` from `a_mid_in`, and `addr_out[19:16]` from `a_top_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; high = address phase |
| ad_in | input | 8 | Processor low pins: address low byte, then data |
| a_mid_in | input | 8 | Processor address bits 15..8 |
| a_top_in | input | 4 | Processor top pins: address bits 19..16, then status |
| dt_r | input | 1 | Data direction: 1 = toward memory, 0 = toward processor |
| den_n | input | 1 | Data buffer enable, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| io_m | input | 1 | Processor space select: 1 = I/O, 0 = memory |
| mem_rdata | input | 8 | Data presented by memory/I-O side |
| addr_out | output | 20 | Demultiplexed address bus |
| mem_wdata | output | 8 | Data driven toward memory side |
| mem_drive_en | output | 1 | Memory-side drive enable |
| cpu_rdata | output | 8 | Data driven toward processor side |
| cpu_drive_en | output | 1 | Processor-side drive enable |
| mem_rd_n | output | 1 | Read strobe to memory side |
| mem_wr_n | output | 1 | Write strobe to memory side |
| mem_io_m | output | 1 | Space select to memory side |

## Verification
Full read and write cycles are run in which the processor pins change after the strobe falls. Data bytes replace the low address byte, and a status nibble that differs from the address replaces the top nibble. A holding latch then shows up as a steady address, and a leaking one shows up as a changed address. Distinct address values with differing bytes in each field tell a correct field placement from a swapped one. The data buffer is run through all four combinations of enable and direction, which separates a correct direction decode from a swapped one and from a buffer that ignores its enable. A capture followed by reset, with the strobe low, tells a cleared hold register from one that keeps old state.

// File: rtl/adl_pkg.sv
package adl_pkg;

    localparam int ADL_LOW_W  = 8;
    localparam int ADL_MID_W  = 8;
    localparam int ADL_TOP_W  = 4;
    localparam int ADL_DATA_W = ADL_LOW_W;
    localparam int ADL_ADDR_W = ADL_LOW_W + ADL_MID_W + ADL_TOP_W;
    localparam int ADL_NGRP   = 3;

    typedef logic [ADL_ADDR_W-1:0] adl_addr_t;
    typedef logic [ADL_DATA_W-1:0] adl_data_t;

    typedef struct packed {
        logic [ADL_TOP_W-1:0] top;
        logic [ADL_MID_W-1:0] mid;
        logic [ADL_LOW_W-1:0] low;
    } adl_pins_t;

    typedef enum logic [1:0] {
        XV_OFF    = 2'b00,
        XV_TO_MEM = 2'b01,
        XV_TO_CPU = 2'b10
    } adl_xv_dir_e;

    function automatic int adl_grp_width(input int g);
        case (g)
            0:       return ADL_LOW_W;
            1:       return ADL_MID_W;
            default: return ADL_TOP_W;
        endcase
    endfunction

    function automatic int adl_grp_offset(input int g);
        case (g)
            0:       return 0;
            1:       return ADL_LOW_W;
            default: return ADL_LOW_W + ADL_MID_W;
        endcase
    endfunction

    // Buffer direction from the active-low enable and the direction pin.
    function automatic adl_xv_dir_e adl_xv_decode(input logic en_n, input logic to_mem);
        if (en_n)
            return XV_OFF;
        else if (to_mem)
            return XV_TO_MEM;
        else
            return XV_TO_CPU;
    endfunction

endpackage

// File: rtl/adl_latch_slice.sv
module adl_latch_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (gate)
            held <= d;
    end

    // Open while gate is high; otherwise show the last captured value.
    assign q = gate ? d : held;

endmodule

// File: rtl/adl_xcvr.sv
module adl_xcvr
    import adl_pkg::*;
(
    input  logic      den_n,
    input  logic      dt_r,
    input  adl_data_t cpu_side,
    input  adl_data_t mem_side,
    output adl_data_t to_mem,
    output logic      to_mem_en,
    output adl_data_t to_cpu,
    output logic      to_cpu_en
);
    adl_xv_dir_e dir;

    always_comb begin
        dir       = adl_xv_decode(den_n, dt_r);
        to_mem_en = (dir == XV_TO_MEM);
        to_cpu_en = (dir == XV_TO_CPU);
        to_mem    = to_mem_en ? cpu_side : '0;
        to_cpu    = to_cpu_en ? mem_side : '0;
    end

endmodule

// File: rtl/adl_demux.sv
module adl_demux
    import adl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ale,
    input  logic [ADL_LOW_W-1:0] ad_in,
    input  logic [ADL_MID_W-1:0] a_mid_in,
    input  logic [ADL_TOP_W-1:0] a_top_in,
    input  logic                 dt_r,
    input  logic                 den_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 io_m,
    input  logic [ADL_DATA_W-1:0] mem_rdata,
    output logic [ADL_ADDR_W-1:0] addr_out,
    output logic [ADL_DATA_W-1:0] mem_wdata,
    output logic                 mem_drive_en,
    output logic [ADL_DATA_W-1:0] cpu_rdata,
    output logic                 cpu_drive_en,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 mem_io_m
);
    adl_pins_t pins;
    adl_addr_t pin_vec;

    always_comb begin
        pins.low = ad_in;
        pins.mid = a_mid_in;
        pins.top = a_top_in;
        pin_vec  = pins;
    end

    // One latch group per address field.
    for (genvar g = 0; g < ADL_NGRP; g++) begin : g_grp
        localparam int W   = adl_grp_width(g);
        localparam int OFS = adl_grp_offset(g);
        adl_latch_slice #(.W(W)) u_slice (
            .clk  (clk),
            .rst  (rst),
            .gate (ale),
            .d    (pin_vec[OFS +: W]),
            .q    (addr_out[OFS +: W])
        );
    end

    adl_xcvr u_xcvr (
        .den_n     (den_n),
        .dt_r      (dt_r),
        .cpu_side  (ad_in),
        .mem_side  (mem_rdata),
        .to_mem    (mem_wdata),
        .to_mem_en (mem_drive_en),
        .to_cpu    (cpu_rdata),
        .to_cpu_en (cpu_drive_en)
    );

    assign mem_rd_n = rd_n;
    assign mem_wr_n = wr_n;
    assign mem_io_m = io_m;

endmodule

// File: rtl/adl_demux_checker.sv
module adl_demux_checker
    import adl_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  ale,
    input logic [ADL_LOW_W-1:0]  ad_in,
    input logic [ADL_MID_W-1:0]  a_mid_in,
    input logic [ADL_TOP_W-1:0]  a_top_in,
    input logic                  dt_r,
    input logic                  den_n,
    input logic                  rd_n,
    input logic                  wr_n,
    input logic                  io_m,
    input logic [ADL_DATA_W-1:0] mem_rdata,
    input logic [ADL_ADDR_W-1:0] addr_out,
    input logic [ADL_DATA_W-1:0] mem_wdata,
    input logic                  mem_drive_en,
    input logic [ADL_DATA_W-1:0] cpu_rdata,
    input logic                  cpu_drive_en,
    input logic                  mem_rd_n,
    input logic                  mem_wr_n,
    input logic                  mem_io_m
);
    p_open_r1: assert property (@(posedge clk) disable iff (rst)
        ale |-> addr_out == {a_top_in, a_mid_in, ad_in});

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ale && !$past(ale) && !$past(rst)) |-> $stable(addr_out));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ale) && !$past(rst)) |-> addr_out == $past({a_top_in, a_mid_in, ad_in}));

    p_to_mem_r5: assert property (@(posedge clk) disable iff (rst)
        (!den_n && dt_r) |-> (mem_drive_en && !cpu_drive_en && mem_wdata == ad_in));

    p_to_cpu_r6: assert property (@(posedge clk) disable iff (rst)
        (!den_n && !dt_r) |-> (cpu_drive_en && !mem_drive_en && cpu_rdata == mem_rdata));

    p_off_r7: assert property (@(posedge clk) disable iff (rst)
        den_n |-> (!mem_drive_en && !cpu_drive_en));

    p_one_side_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_drive_en, cpu_drive_en}));

    p_strobes_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_n == rd_n) && (mem_wr_n == wr_n) && (mem_io_m == io_m));

endmodule

bind adl_demux adl_demux_checker u_chk (.*);

// File: tb/adl_demux_test.sv
`timescale 1ns/1ps
module adl_demux_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  a_mid_in = '0;
    logic [3:0]  a_top_in = '0;
    logic        dt_r = 1'b0;
    logic        den_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        io_m = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [19:0] addr_out;
    logic [7:0]  mem_wdata;
    logic        mem_drive_en;
    logic [7:0]  cpu_rdata;
    logic        cpu_drive_en;
    logic        mem_rd_n;
    logic        mem_wr_n;
    logic        mem_io_m;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adl_demux uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Address phase: present the address and open the latches.
    task automatic addr_phase(input logic [19:0] a, input logic space);
        ale = 1'b1; ad_in = a[7:0]; a_mid_in = a[15:8]; a_top_in = a[19:16];
        io_m = space; den_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        #1;
        chk("R1 transparent", addr_out, a);
        chk("R9 low field", addr_out[7:0], a[7:0]);
        chk("R9 top field", addr_out[19:16], a[19:16]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        addr_phase(20'hABCDE, 1'b0);
        step;
        ale = 1'b0; rst = 1'b1;
        step; step;
        rst = 1'b0;
        step;
        chk("R4 reset clears held address", addr_out, 20'h0);
        chk("R7 idle mem enable", mem_drive_en, 0);
        chk("R7 idle cpu enable", cpu_drive_en, 0);
    endtask

    task automatic t_read(input logic [19:0] a, input logic [3:0] stat,
                          input logic [7:0] d, input logic space);
        addr_phase(a, space);
        step;
        ale = 1'b0; dt_r = 1'b0; a_top_in = stat; ad_in = 8'h5A ^ a[7:0];
        a_mid_in = ~a[15:8];
        rd_n = 1'b0; den_n = 1'b0; mem_rdata = d;
        #1;
        chk("R2 held after fall", addr_out, a);
        chk("R3 status blocked", addr_out[19:16], a[19:16]);
        chk("R6 cpu enable", cpu_drive_en, 1);
        chk("R6 cpu data", cpu_rdata, d);
        chk("R6 mem side quiet", mem_drive_en, 0);
        chk("R8 read strobe", mem_rd_n, 0);
        chk("R8 space select", mem_io_m, space);
        step;
        a_top_in = ~stat; ad_in = ~d;
        #1;
        chk("R2 held later", addr_out, a);
        step;
        rd_n = 1'b1; den_n = 1'b1;
        #1;
        chk("R7 enable off cpu", cpu_drive_en, 0);
        chk("R7 data zero", cpu_rdata, 0);
        chk("R8 read strobe released", mem_rd_n, 1);
        chk("R3 held at cycle end", addr_out, a);
        step;
    endtask

    task automatic t_write(input logic [19:0] a, input logic [3:0] stat,
                           input logic [7:0] d, input logic space);
        addr_phase(a, space);
        dt_r = 1'b1;
        step;
        ale = 1'b0; a_top_in = stat; ad_in = d; wr_n = 1'b0; den_n = 1'b0;
        mem_rdata = ~d;
        #1;
        chk("R3 status blocked wr", addr_out, a);
        chk("R5 mem enable", mem_drive_en, 1);
        chk("R5 mem data", mem_wdata, d);
        chk("R5 cpu side quiet", cpu_drive_en, 0);
        chk("R8 write strobe", mem_wr_n, 0);
        step;
        wr_n = 1'b1; den_n = 1'b1;
        #1;
        chk("R7 enable off mem", mem_drive_en, 0);
        chk("R7 mem data zero", mem_wdata, 0);
        step;
    endtask

    task automatic t_buffer_off;
        for (int i = 0; i < 2; i++) begin
            den_n = 1'b1; dt_r = i[0]; ad_in = 8'hC3; mem_rdata = 8'h3C;
            #1;
            chk("R7 both off", {mem_drive_en, cpu_drive_en}, 0);
            chk("R7 outputs zero", {mem_wdata, cpu_rdata}, 0);
            step;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_read(20'h91234, 4'h6, 8'h77, 1'b0);
        t_read(20'h0F0A5, 4'hC, 8'h81, 1'b1);
        t_write(20'h5A3C7, 4'h9, 8'hE2, 1'b0);
        t_write(20'hFFFFF, 4'h0, 8'h14, 1'b1);
        t_buffer_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule